// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment-relative reference into a 20-bit physical memory address. It keeps four 16-bit segment base registers: extra, code, stack and data. A software-visible write port loads these registers. On each request the caller gives an access kind and a 16-bit offset. The block picks the base register that belongs to that access kind, moves the base four bit positions up and adds the offset. The result is a 20-bit address, so a segment covers 64 KB and always starts on a 16-byte boundary.

An optional override input lets the caller choose a different base register for most access kinds. The destination of a string move is the exception: it always uses the extra segment. The address is registered and appears one clock after the request, together with a valid flag. The offset itself is computed elsewhere, and the memory bus is handled elsewhere.

Top module: `seg_addr_gen`

## Requirements
- R1: When `addr_valid` is high, `phys_addr` equals (selected segment base × 16) + `offset`, taken from the inputs of the previous cycle.
- R2: A sum that does not fit in 20 bits wraps modulo 2^20. For example, base FFFF with offset 0020 gives 00010.
- R3: Access kind 0 (instruction fetch) uses the code segment when no override is given.
- R4: Access kinds 1 (stack through the stack pointer) and 2 (stack through the base pointer) use the stack segment when no override is given.
- R5: Access kind 3 (general data) uses the data segment when no override is given. The unused kinds 5, 6 and 7 behave the same way.
- R6: Access kind 4 (string destination) always uses the extra segment, whatever `ovr_en` and `ovr_idx` say.
- R7: For every access kind except 4, `ovr_en` = 1 makes the block use the segment named by `ovr_idx` instead of the default.
- R8: Segment register indices are 0 = extra, 1 = code, 2 = stack and 3 = data. All four registers are zero after reset. A write loads its register at the next clock edge, so a request in the same cycle as the write still uses the old base.
- R9: `addr_valid` is `req_valid` delayed by one cycle. While no request is made, `phys_addr` keeps its last value.
- R10: During reset, `addr_valid` and `phys_addr` are both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Load a segment base register |
| seg_wr_idx | input | 2 | Register to load (0 extra, 1 code, 2 stack, 3 data) |
| seg_wr_val | input | 16 | New base value |
| req_valid | input | 1 | An address is requested this cycle |
| acc_kind | input | 3 | Access kind (0 fetch, 1 SP stack, 2 BP stack, 3 data, 4 string destination) |
| ovr_en | input | 1 | Use `ovr_idx` instead of the default segment |
| ovr_idx | input | 2 | Segment chosen by the override |
| offset | input | 16 | 16-bit offset within the segment |
| addr_valid | output | 1 | `phys_addr` holds a new result |
| phys_addr | output | 20 | Physical address |

## Verification
The in-RTL assertions check these rules on every cycle:
- Each base register loads exactly the written value and holds it when it is not written.
- The valid flag follows the request by one cycle, and the address holds while idle.
- The low four address bits pass through from the offset.
- The segment selector obeys the fetch default, the override and the forced string-destination rule.

Only the bench scenarios show the following:
- The full arithmetic against known pairs, such as A4FB:4872 giving A9822 and 34BA:8AB4 giving 3D654.
- Wrap-around above 20 bits.
- The reserved access kinds.
- A write and a request in the same cycle, which must see the old base.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

   // Access kinds presented on acc_kind; codes 5..7 are unused and act as data
   typedef enum logic [2:0] {
      ACC_FETCH   = 3'd0,
      ACC_STK_SP  = 3'd1,
      ACC_STK_BP  = 3'd2,
      ACC_DATA    = 3'd3,
      ACC_STR_DST = 3'd4
   } acc_e;

   // Segment base register indices
   typedef enum logic [1:0] {
      SEG_EXTRA = 2'd0,
      SEG_CODE  = 2'd1,
      SEG_STACK = 2'd2,
      SEG_DATA  = 2'd3
   } seg_e;

   localparam int NUM_SEG = 4;

endpackage

// File: rtl/seg_bank.sv
module seg_bank #(
   parameter int SEG_W = 16,
   parameter int NSEG  = 4,
   localparam int IDX_W = $clog2(NSEG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [SEG_W-1:0] wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [SEG_W-1:0] rd_data
);

   if (NSEG < 2 || NSEG != (1 << IDX_W)) begin : g_bad_nseg
      $error("seg_bank: NSEG must be a power of two and at least 2");
   end
   if (SEG_W < 1) begin : g_bad_width
      $error("seg_bank: SEG_W must be positive");
   end

   logic [SEG_W-1:0] bank_q [NSEG];

   for (genvar g = 0; g < NSEG; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            bank_q[g] <= '0;
         else if (wr_en && wr_idx == IDX_W'(g))
            bank_q[g] <= wr_data;
      end

      // R8: a write lands at the next edge with exactly the written value
      p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_idx == IDX_W'(g)) |=> (bank_q[g] == $past(wr_data)));

      // R8: untouched registers keep their contents
      p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && wr_idx == IDX_W'(g)) |=> $stable(bank_q[g]));
   end

   assign rd_data = bank_q[rd_idx];

endmodule

// File: rtl/seg_pick.sv
module seg_pick
   import seg_addr_pkg::*;
(
   input  logic [2:0] acc_i,
   input  logic       ovr_en_i,
   input  logic [1:0] ovr_idx_i,
   output seg_e       idx_o
);

   seg_e dflt;

   always_comb begin
      case (acc_i)
         ACC_FETCH:   dflt = SEG_CODE;
         ACC_STK_SP,
         ACC_STK_BP:  dflt = SEG_STACK;
         ACC_STR_DST: dflt = SEG_EXTRA;
         default:     dflt = SEG_DATA;
      endcase
   end

   always_comb begin
      if (ovr_en_i && acc_i != ACC_STR_DST)
         idx_o = seg_e'(ovr_idx_i);
      else
         idx_o = dflt;
   end

endmodule

// File: rtl/addr_sum.sv
module addr_sum #(
   parameter int SEG_W = 16,
   parameter int OFF_W = 16,
   parameter int SHIFT = 4,
   parameter bit SPLIT = 1'b1,
   localparam int PA_W = SEG_W + SHIFT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic [SEG_W-1:0] seg_i,
   input  logic [OFF_W-1:0] off_i,
   output logic             vld_o,
   output logic [PA_W-1:0]  addr_o
);

   if (SHIFT < 1) begin : g_bad_shift
      $error("addr_sum: SHIFT must be at least 1");
   end
   if (OFF_W > PA_W || OFF_W <= SHIFT) begin : g_bad_off
      $error("addr_sum: OFF_W must lie in (SHIFT, SEG_W+SHIFT]");
   end

   logic [PA_W-1:0] sum;

   if (SPLIT) begin : g_split
      // Low bits pass through; only the overlapping part needs an adder
      logic [SEG_W-1:0] hi_sum;
      assign hi_sum = seg_i + SEG_W'(off_i >> SHIFT);
      assign sum    = {hi_sum, off_i[SHIFT-1:0]};
   end else begin : g_full
      assign sum = {seg_i, {SHIFT{1'b0}}} + PA_W'(off_i);
   end

   logic            vld_q;
   logic [PA_W-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         addr_q <= '0;
      end else begin
         vld_q <= req_i;
         if (req_i)
            addr_q <= sum;
      end
   end

   assign vld_o  = vld_q;
   assign addr_o = addr_q;

   // R1: the low bits of a result are the low bits of its offset
   p_lownib_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> (addr_o[SHIFT-1:0] == $past(off_i[SHIFT-1:0])));

   // R9: a request yields a valid result one cycle later
   p_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> vld_o);

   // R9: no request, no valid, address held
   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> (!vld_o && $stable(addr_o)));

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
   import seg_addr_pkg::*;
#(
   parameter int SEG_W     = 16,
   parameter int OFF_W     = 16,
   parameter int SHIFT     = 4,
   parameter bit SPLIT_ADD = 1'b1,
   localparam int PA_W  = SEG_W + SHIFT,
   localparam int IDX_W = $clog2(NUM_SEG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seg_wr_en,
   input  logic [1:0]       seg_wr_idx,
   input  logic [SEG_W-1:0] seg_wr_val,
   input  logic             req_valid,
   input  logic [2:0]       acc_kind,
   input  logic             ovr_en,
   input  logic [1:0]       ovr_idx,
   input  logic [OFF_W-1:0] offset,
   output logic             addr_valid,
   output logic [PA_W-1:0]  phys_addr
);

   if (IDX_W != 2) begin : g_bad_idx
      $error("seg_addr_gen: the selector expects four segment registers");
   end

   seg_e             sel_idx;
   logic [SEG_W-1:0] sel_base;

   seg_pick u_pick (
      .acc_i     (acc_kind),
      .ovr_en_i  (ovr_en),
      .ovr_idx_i (ovr_idx),
      .idx_o     (sel_idx)
   );

   seg_bank #(.SEG_W(SEG_W), .NSEG(NUM_SEG)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (seg_wr_en),
      .wr_idx  (seg_wr_idx),
      .wr_data (seg_wr_val),
      .rd_idx  (sel_idx),
      .rd_data (sel_base)
   );

   addr_sum #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .SPLIT(SPLIT_ADD)) u_sum (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (req_valid),
      .seg_i  (sel_base),
      .off_i  (offset),
      .vld_o  (addr_valid),
      .addr_o (phys_addr)
   );

   // R6: string destination is pinned to the extra segment
   p_strdst_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && acc_kind == 3'd4) |-> (sel_idx == SEG_EXTRA));

   // R3: fetch without override reads the code segment
   p_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && acc_kind == 3'd0 && !ovr_en) |-> (sel_idx == SEG_CODE));

   // R7: override wins for every kind except string destination
   p_ovr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ovr_en && acc_kind != 3'd4) |-> (sel_idx == seg_e'(ovr_idx)));

endmodule

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        seg_wr_en = 1'b0;
   logic [1:0]  seg_wr_idx = '0;
   logic [15:0] seg_wr_val = '0;
   logic        req_valid = 1'b0;
   logic [2:0]  acc_kind = '0;
   logic        ovr_en = 1'b0;
   logic [1:0]  ovr_idx = '0;
   logic [15:0] offset = '0;
   logic        addr_valid;
   logic [19:0] phys_addr;

   always #4 clk = ~clk;

   seg_addr_gen u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .seg_wr_en  (seg_wr_en),
      .seg_wr_idx (seg_wr_idx),
      .seg_wr_val (seg_wr_val),
      .req_valid  (req_valid),
      .acc_kind   (acc_kind),
      .ovr_en     (ovr_en),
      .ovr_idx    (ovr_idx),
      .offset     (offset),
      .addr_valid (addr_valid),
      .phys_addr  (phys_addr)
   );

   int          total = 0;
   int          bad = 0;
   logic        mon_on = 1'b0;
   logic [15:0] shadow [4];
   logic [19:0] q_addr [$];
   string       q_tag [$];
   logic [19:0] last_addr = '0;

   task automatic chk(input logic ok, input string tag,
                      input logic [19:0] got, input logic [19:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // driver: one call per cycle; expected value uses the base before any same-cycle write
   task automatic op(input logic we, input logic [1:0] wi, input logic [15:0] wv,
                     input logic rq, input logic [2:0] ak, input logic oe,
                     input logic [1:0] oi, input logic [15:0] off,
                     input logic [1:0] exp_idx, input string tag);
      @(negedge clk);
      seg_wr_en  = we;
      seg_wr_idx = wi;
      seg_wr_val = wv;
      req_valid  = rq;
      acc_kind   = ak;
      ovr_en     = oe;
      ovr_idx    = oi;
      offset     = off;
      if (rq) begin
         q_addr.push_back({shadow[exp_idx], 4'h0} + 20'(off));
         q_tag.push_back(tag);
      end
      if (we) shadow[wi] = wv;
   endtask

   task automatic idle();
      op(1'b0, 2'd0, 16'h0, 1'b0, 3'd0, 1'b0, 2'd0, 16'h0, 2'd0, "idle");
   endtask

   task automatic wr(input logic [1:0] wi, input logic [15:0] wv);
      op(1'b1, wi, wv, 1'b0, 3'd0, 1'b0, 2'd0, 16'h0, 2'd0, "write");
   endtask

   // monitor: results due this cycle are exactly the items queued before this edge
   initial begin
      wait (mon_on);
      forever begin
         @(posedge clk);
         #1;
         if (q_addr.size() > 0) begin
            logic [19:0] e;
            string       t;
            e = q_addr.pop_front();
            t = q_tag.pop_front();
            chk(addr_valid === 1'b1 && phys_addr === e, t, phys_addr, e);
            last_addr = phys_addr;
         end else begin
            chk(addr_valid === 1'b0 && phys_addr === last_addr,
                "R9 idle hold", phys_addr, last_addr);
         end
      end
   end

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: got %h expected %h", 20'h0, 20'h1);
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) shadow[i] = 16'h0;
      repeat (3) @(negedge clk);
      // R10: outputs cleared during reset
      chk(addr_valid === 1'b0, "R10 valid in reset", 20'(addr_valid), 20'h0);
      chk(phys_addr === 20'h0, "R10 addr in reset", phys_addr, 20'h0);
      @(negedge clk);
      rst_n  = 1'b1;
      mon_on = 1'b1;

      // R8: bases are zero after reset
      op(1'b0, 2'd0, 16'h0, 1'b1, 3'd3, 1'b0, 2'd0, 16'h1234, 2'd3, "R8 zero base");

      wr(2'd1, 16'h34BA);
      wr(2'd3, 16'hA4FB);
      wr(2'd0, 16'h5000);
      wr(2'd2, 16'h695E);

      op(1'b0, 2'd0, 16'h0, 1'b1, 3'd0, 1'b0, 2'd0, 16'h8AB4, 2'd1, "R1 R3 fetch");
      op(1'b0, 2'd0, 16'h0, 1'b1, 3'd3, 1'b0, 2'd0, 16'h4872, 2'd3, "R1 R5 data");
      for (int k = 5; k < 8; k++)
         op(1'b0, 2'd0, 16'h0, 1'b1, 3'(k), 1'b0, 2'd0, 16'h0003, 2'd3, "R5 reserved kind");
      op(1'b0, 2'd0, 16'h0, 1'b1, 3'd1, 1'b0, 2'd0, 16'h0010, 2'd2, "R4 sp stack");
      op(1'b0, 2'd0, 16'h0, 1'b1, 3'd2, 1'b0, 2'd0, 16'hFFFF, 2'd2, "R4 bp stack");
      op(1'b0, 2'd0, 16'h0, 1'b1, 3'd4, 1'b0, 2'd0, 16'h0007, 2'd0, "R6 string dst");
      op(1'b0, 2'd0, 16'h0, 1'b1, 3'd4, 1'b1, 2'd1, 16'h0008, 2'd0, "R6 override ignored");
      op(1'b0, 2'd0, 16'h0, 1'b1, 3'd0, 1'b1, 2'd3, 16'h0001, 2'd3, "R7 fetch override");
      op(1'b0, 2'd0, 16'h0, 1'b1, 3'd1, 1'b1, 2'd0, 16'h0002, 2'd0, "R7 stack override");
      op(1'b0, 2'd0, 16'h0, 1'b1, 3'd3, 1'b1, 2'd2, 16'h0004, 2'd2, "R7 data override");
      idle();
      idle();

      wr(2'd3, 16'hFFFF);
      op(1'b0, 2'd0, 16'h0, 1'b1, 3'd3, 1'b0, 2'd0, 16'h0020, 2'd3, "R2 wrap small");
      op(1'b0, 2'd0, 16'h0, 1'b1, 3'd3, 1'b0, 2'd0, 16'hFFFF, 2'd3, "R2 wrap max");

      // R8: write and request in one cycle sees the old base, next cycle the new
      op(1'b1, 2'd3, 16'h1000, 1'b1, 3'd3, 1'b0, 2'd0, 16'h0000, 2'd3, "R8 same-cycle write");
      op(1'b0, 2'd0, 16'h0, 1'b1, 3'd3, 1'b0, 2'd0, 16'h0000, 2'd3, "R8 new base");
      idle();
      idle();
      idle();

      summary();
      $finish;
   end

endmodule